// File: doc/BRIEF.md
# Neural Crossbar Match Scheduler

This block picks a conflict-free configuration for a square N×N input-queued crossbar. It uses a grid of one-bit threshold neurons, one for each crosspoint. A start pulse captures the pending request matrix, a small priority level for each request, and a set of signed tuning weights. At that point every requested neuron is switched on. On each clock after that, all neurons recompute together. A neuron's net input is its bias, plus its priority times a step weight, minus an inhibition weight times the number of other active neurons in its row, minus another weight times the number of other active neurons in its column. The neuron turns on only when that sum is strictly positive.

The network stops iterating in one of two ways. It stops when an iteration leaves the neuron matrix unchanged. It also stops when a programmable iteration limit is reached. A final pass then removes any remaining row or column conflicts. The result is presented for one cycle, together with a done pulse and the number of iterations used. A scheduler loop starts a job, waits for done, and applies the grant matrix to the fabric.

Top module: `xbs_sched`

## Requirements
- R1: After reset, busy, done, grant and iters are all zero.
- R2: A start pulse seen while idle captures req, prio and the weights, and sets each neuron equal to its request bit. If the requests share no row and no column, every one of them is granted, and iters is 1, because the first iteration changes nothing.
- R3: A crosspoint with no request is never granted, even when its bias and priority terms are positive. Bit i*N+j of req and of grant is input i to output j.
- R4: A neuron's next state is 1 only if it is requested and bias + prio*prio_step - row_wt*(other active neurons in its row) - col_wt*(other active neurons in its column) > 0. With requests at (1,1), (1,3) and (3,1), bias 10 and both weights 6, the blocking crosspoint (1,1) turns off. The grants are (1,3) and (3,1), with iters 2.
- R5: The priority of crosspoint (i,j) is bits (i*N+j)*PRIO_W upward of prio, and each level adds prio_step to that neuron's net input. With (0,0) at level 0 and (0,1) at level 3, bias 2, step 4 and row weight 8, only (0,1) is granted, with iters 2.
- R6: Iteration stops after max_iter iterations if the matrix has not settled first, and a max_iter of 0 behaves as 1. iters reports the number of iterations run.
- R7: The cleanup pass first keeps only the lowest-column active neuron in each row. It then keeps only the lowest-row survivor in each column.
- R8: In every delivered grant, each row and each column has at most one bit set.
- R9: done is high for exactly one cycle. busy is high from the cycle after start is accepted until done rises. grant and iters hold their values until the next done.
- R10: A start pulse while busy is ignored. The running job finishes with its own captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job when idle |
| req | input | N*N | Request matrix, bit i*N+j is input i to output j |
| prio | input | N*N*PRIO_W | Priority level for each crosspoint |
| row_wt | input | WGT_W | Row inhibition weight (unsigned) |
| col_wt | input | WGT_W | Column inhibition weight (unsigned) |
| bias | input | WGT_W | Bias term (signed) |
| prio_step | input | WGT_W | Net-input gain per priority level (unsigned) |
| max_iter | input | ITER_W | Iteration limit |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle result strobe |
| grant | output | N*N | Exclusive grant matrix |
| iters | output | ITER_W | Iterations used by the last job |

## Verification
The checks assume that start arrives as a clean pulse away from reset. They also assume that the weights and the limit are only meaningful as captured at start. Because of this, the subset check compares grant against the captured request matrix rather than the live one, and the stability check only covers the captured matrix while a job runs.

The stimulus holds every configuration input constant from its start pulse to done. The single exception is the scenario that pulses start in the middle of a job to show that the pulse is ignored. The weights are chosen so that each case either settles in a known number of iterations or oscillates with period two. With period two, the state at the iteration limit can be predicted exactly.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
    localparam int XBS_N      = 16;
    localparam int XBS_PRIO_W = 2;
    localparam int XBS_WGT_W  = 8;
    localparam int XBS_ITER_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAN = 2'd2
    } xbs_state_t;

    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/xbs_neuron.sv
module xbs_neuron #(
    parameter int N      = 16,
    parameter int PRIO_W = 2,
    parameter int WGT_W  = 8,
    localparam int CNT_W = xbs_pkg::cnt_width(N),
    localparam int ACC_W = WGT_W + CNT_W + PRIO_W + 3
) (
    input  logic                    req_bit,
    input  logic                    cur,
    input  logic [PRIO_W-1:0]       level,
    input  logic [CNT_W-1:0]        row_on,
    input  logic [CNT_W-1:0]        col_on,
    input  logic [WGT_W-1:0]        row_wt,
    input  logic [WGT_W-1:0]        col_wt,
    input  logic signed [WGT_W-1:0] bias,
    input  logic [WGT_W-1:0]        prio_step,
    output logic                    nxt
);
    logic [CNT_W-1:0]        row_oth, col_oth;
    logic signed [ACC_W-1:0] t_bias, t_prio, t_row, t_col, net;

    always_comb begin
        // exclude this neuron from its own inhibition counts
        row_oth = row_on - CNT_W'(cur);
        col_oth = col_on - CNT_W'(cur);
        t_bias  = {{(ACC_W-WGT_W){bias[WGT_W-1]}}, bias};
        t_prio  = ACC_W'(level) * ACC_W'(prio_step);
        t_row   = ACC_W'(row_wt) * ACC_W'(row_oth);
        t_col   = ACC_W'(col_wt) * ACC_W'(col_oth);
        net     = t_bias + t_prio - t_row - t_col;
        nxt     = req_bit && (net > 0);
    end
endmodule

// File: rtl/xbs_cleanup.sv
module xbs_cleanup #(
    parameter int N = 16
) (
    input  logic [N-1:0][N-1:0] act,
    output logic [N-1:0][N-1:0] excl
);
    logic [N-1:0][N-1:0] row_kept;
    logic                seen;

    always_comb begin
        row_kept = '0;
        excl     = '0;
        seen     = 1'b0;
        // pass 1: lowest column wins in each row
        for (int i = 0; i < N; i++) begin
            seen = 1'b0;
            for (int j = 0; j < N; j++) begin
                row_kept[i][j] = act[i][j] && !seen;
                seen = seen || act[i][j];
            end
        end
        // pass 2: lowest row wins in each column
        for (int j = 0; j < N; j++) begin
            seen = 1'b0;
            for (int i = 0; i < N; i++) begin
                excl[i][j] = row_kept[i][j] && !seen;
                seen = seen || row_kept[i][j];
            end
        end
    end
endmodule

// File: rtl/xbs_sched.sv
module xbs_sched
    import xbs_pkg::*;
#(
    parameter int N      = XBS_N,
    parameter int PRIO_W = XBS_PRIO_W,
    parameter int WGT_W  = XBS_WGT_W,
    parameter int ITER_W = XBS_ITER_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [N*N-1:0]            req,
    input  logic [N*N*PRIO_W-1:0]     prio,
    input  logic [WGT_W-1:0]          row_wt,
    input  logic [WGT_W-1:0]          col_wt,
    input  logic signed [WGT_W-1:0]   bias,
    input  logic [WGT_W-1:0]          prio_step,
    input  logic [ITER_W-1:0]         max_iter,
    output logic                      busy,
    output logic                      done,
    output logic [N*N-1:0]            grant,
    output logic [ITER_W-1:0]         iters
);
    localparam int CNT_W = cnt_width(N);

    xbs_state_t                   state;
    logic [N-1:0][N-1:0]          req_q, y, y_next, cleaned;
    logic [N*N-1:0][PRIO_W-1:0]   prio_q;
    logic [WGT_W-1:0]             row_wt_q, col_wt_q, step_q;
    logic signed [WGT_W-1:0]      bias_q;
    logic [ITER_W-1:0]            max_q, iter_cnt;
    logic [N-1:0][CNT_W-1:0]      row_cnt, col_cnt;
    logic                         last_iter;

    // active-neuron counts per row and per column
    always_comb begin
        row_cnt = '0;
        col_cnt = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                row_cnt[i] = row_cnt[i] + CNT_W'(y[i][j]);
                col_cnt[j] = col_cnt[j] + CNT_W'(y[i][j]);
            end
        end
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            xbs_neuron #(.N(N), .PRIO_W(PRIO_W), .WGT_W(WGT_W)) u_neuron (
                .req_bit   (req_q[gi][gj]),
                .cur       (y[gi][gj]),
                .level     (prio_q[gi*N+gj]),
                .row_on    (row_cnt[gi]),
                .col_on    (col_cnt[gj]),
                .row_wt    (row_wt_q),
                .col_wt    (col_wt_q),
                .bias      (bias_q),
                .prio_step (step_q),
                .nxt       (y_next[gi][gj])
            );
        end
    end

    xbs_cleanup #(.N(N)) u_cleanup (
        .act  (y),
        .excl (cleaned)
    );

    assign last_iter = ({1'b0, iter_cnt} + (ITER_W+1)'(1)) >= {1'b0, max_q};
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_q    <= '0;
            prio_q   <= '0;
            y        <= '0;
            row_wt_q <= '0;
            col_wt_q <= '0;
            step_q   <= '0;
            bias_q   <= '0;
            max_q    <= '0;
            iter_cnt <= '0;
            done     <= 1'b0;
            grant    <= '0;
            iters    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    req_q    <= req;
                    prio_q   <= prio;
                    y        <= req;
                    row_wt_q <= row_wt;
                    col_wt_q <= col_wt;
                    step_q   <= prio_step;
                    bias_q   <= bias;
                    max_q    <= max_iter;
                    iter_cnt <= '0;
                    state    <= ST_RUN;
                end
                ST_RUN: begin
                    y        <= y_next;
                    iter_cnt <= iter_cnt + ITER_W'(1);
                    if ((y_next == y) || last_iter) state <= ST_CLEAN;
                end
                ST_CLEAN: begin
                    grant <= cleaned;
                    iters <= iter_cnt;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbs_sched_chk.sv
module xbs_sched_chk #(
    parameter int N      = 16,
    parameter int ITER_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                done,
    input logic [N*N-1:0]      grant,
    input logic [ITER_W-1:0]   iters,
    input logic [N-1:0][N-1:0] req_q,
    input logic [ITER_W-1:0]   max_q
);
    logic [N-1:0][N-1:0] gm;
    assign gm = grant;

    for (genvar k = 0; k < N; k++) begin : g_line
        logic [N-1:0] col_bits;
        for (genvar r = 0; r < N; r++) begin : g_c
            assign col_bits[r] = gm[r][k];
        end
        // R8: row exclusivity
        a_r8_row_excl: assert property (@(posedge clk) disable iff (rst)
            done |-> $onehot0(gm[k]));
        // R8: column exclusivity
        a_r8_col_excl: assert property (@(posedge clk) disable iff (rst)
            done |-> $onehot0(col_bits));
    end

    // R3: only captured requests may be granted
    a_r3_grant_has_req: assert property (@(posedge clk) disable iff (rst)
        done |-> ((grant & ~req_q) == '0));

    // R6: iteration count within the limit
    a_r6_iters_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> (iters != '0) && ((iters <= max_q) || (max_q == '0)));

    // R9: done lasts one cycle and closes a busy period
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy) && !busy);

    // R10: captured requests stay fixed while running
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(req_q));
endmodule

bind xbs_sched xbs_sched_chk #(.N(N), .ITER_W(ITER_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .busy  (busy),
    .done  (done),
    .grant (grant),
    .iters (iters),
    .req_q (req_q),
    .max_q (max_q)
);

// File: tb/tb_xbs_sched.sv
module tb_xbs_sched;
    localparam int N = 16;
    localparam int PW = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [N*N-1:0]     req = '0;
    logic [N*N*PW-1:0]  prio = '0;
    logic [7:0]         row_wt = '0, col_wt = '0, prio_step = '0, max_iter = '0;
    logic signed [7:0]  bias = '0;
    logic               busy, done;
    logic [N*N-1:0]     grant;
    logic [7:0]         iters;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [N*N-1:0] got_g;
    logic [7:0]     got_i;

    always #2 clk = ~clk;

    xbs_sched dut (
        .clk(clk), .rst(rst), .start(start), .req(req), .prio(prio),
        .row_wt(row_wt), .col_wt(col_wt), .bias(bias), .prio_step(prio_step),
        .max_iter(max_iter), .busy(busy), .done(done), .grant(grant), .iters(iters)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic int ix(input int i, input int j);
        return i * N + j;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N*N-1:0] act,
                         input logic [N*N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [7:0] rw, input logic [7:0] cw, input logic signed [7:0] b,
                         input logic [7:0] ps, input logic [7:0] mi);
        row_wt = rw; col_wt = cw; bias = b; prio_step = ps; max_iter = mi;
    endtask

    task automatic run_job(input logic [N*N-1:0] r);
        int w;
        @(negedge clk); req = r; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", N*N'(busy), N*N'(1));
        w = 0;
        while (!done && w < 1000) begin @(negedge clk); w++; end
        got_g = grant; got_i = iters;
        check(done == 1'b1, "R9 done seen", N*N'(done), N*N'(1));
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0, "R1 reset busy/done", N*N'({busy, done}), '0);
        check(grant == '0 && iters == '0, "R1 reset grant/iters", grant, '0);
    endtask

    task automatic t_diag();
        logic [N*N-1:0] r = '0;
        for (int i = 0; i < N; i++) r[ix(i, (i + 3) % N)] = 1'b1;
        setup(8'd8, 8'd8, 8'sd4, 8'd0, 8'd10);
        prio = '0;
        run_job(r);
        check(got_g == r, "R2 disjoint requests all granted", got_g, r);
        check(got_i == 8'd1, "R2 iters one", N*N'(got_i), N*N'(1));
        check(got_g[ix(0, 0)] == 1'b0 && got_g[ix(5, 5)] == 1'b0,
              "R3 unrequested crosspoint not granted", got_g, r);
    endtask

    task automatic t_example();
        logic [N*N-1:0] r = '0, e = '0;
        r[ix(1, 1)] = 1; r[ix(1, 3)] = 1; r[ix(3, 1)] = 1;
        e[ix(1, 3)] = 1; e[ix(3, 1)] = 1;
        setup(8'd6, 8'd6, 8'sd10, 8'd0, 8'd10);
        prio = '0;
        run_job(r);
        check(got_g == e, "R4 blocking request suppressed", got_g, e);
        check(got_i == 8'd2, "R4 iters two", N*N'(got_i), N*N'(2));
    endtask

    task automatic t_prio();
        logic [N*N-1:0] r = '0, e = '0;
        r[ix(0, 0)] = 1; r[ix(0, 1)] = 1; e[ix(0, 1)] = 1;
        setup(8'd8, 8'd8, 8'sd2, 8'd4, 8'd10);
        prio = '0;
        prio[ix(0, 1)*PW +: PW] = 2'd3;
        run_job(r);
        check(got_g == e, "R5 higher priority wins", got_g, e);
        check(got_i == 8'd2, "R5 iters two", N*N'(got_i), N*N'(2));
        prio = '0;
    endtask

    task automatic t_cap();
        logic [N*N-1:0] r = '0, e = '0;
        r[ix(2, 0)] = 1; r[ix(2, 5)] = 1; e[ix(2, 0)] = 1;
        // period-two oscillation: on after even iteration counts
        setup(8'd8, 8'd8, 8'sd4, 8'd0, 8'd4);
        run_job(r);
        check(got_i == 8'd4, "R6 stops at limit", N*N'(got_i), N*N'(4));
        check(got_g == e, "R7 cleanup keeps lowest column", got_g, e);
        setup(8'd8, 8'd8, 8'sd4, 8'd0, 8'd0);
        run_job(r);
        check(got_i == 8'd1, "R6 zero limit acts as one", N*N'(got_i), N*N'(1));
        check(got_g == '0, "R6 state after one iteration", got_g, '0);
    endtask

    task automatic t_full();
        logic [N*N-1:0] r = '1, e = '0;
        e[ix(0, 0)] = 1;
        setup(8'd1, 8'd1, 8'sd4, 8'd0, 8'd6);
        run_job(r);
        check(got_g == e, "R7 row then column cleanup", got_g, e);
        check(got_i == 8'd6, "R6 full grid limit", N*N'(got_i), N*N'(6));
        for (int k = 0; k < N; k++)
            check($countones(got_g[k*N +: N]) <= 1, "R8 row exclusive", got_g, e);
    endtask

    task automatic t_pulse_hold();
        logic [N*N-1:0] r = '0, e = '0, d = '0;
        r[ix(2, 0)] = 1; r[ix(2, 5)] = 1; e[ix(2, 0)] = 1;
        for (int i = 0; i < N; i++) d[ix(i, i)] = 1'b1;
        setup(8'd8, 8'd8, 8'sd4, 8'd0, 8'd20);
        @(negedge clk); req = r; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        req = d; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        check(grant == e, "R10 mid-run start ignored", grant, e);
        check(iters == 8'd20, "R10 first job iterations", N*N'(iters), N*N'(20));
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9 done single cycle", N*N'({done, busy}), '0);
        check(grant == e, "R9 grant held", grant, e);
        repeat (5) @(negedge clk);
        check(grant == e && iters == 8'd20, "R9 result held while idle", grant, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_diag();
        t_example();
        t_prio();
        t_cap();
        t_full();
        t_pulse_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule